// File: doc/BRIEF.md
# Normalized Span Interpolation Stage

This block is one link in a chain of identical stages that fill the interior of a scan line. Each stage owns a window of `PIX` consecutive pixels (16 by default) on one scan line. A stage does not know where its window sits on the screen. Every span packet it receives gives its start and stop positions relative to the stage's own window.

A packet arrives over a valid/ready handshake. It holds the following:
- the start and stop positions of the span;
- the shared divisor;
- a depth-test enable bit;
- for each of the red, green, blue and depth channels, the current value, the per-pixel whole step, the fractional step and the running error.

When the start lies inside the window, the stage walks an incremental line-drawing (DDA) stepper across the covered pixels. It issues one pixel write per cycle, and each write is qualified by a local depth test. When the span ends inside the window, the packet is dropped. Otherwise the stage shifts both positions down by `PIX` and hands the packet to the next stage. The forwarded packet carries the attribute values and errors that belong to the next pixel.

A packet whose start lies beyond the window is shifted and passed on at once, without touching any pixel. Since every stage does the same thing, a row of stages is built by repeating the stage, with no per-stage configuration.

Top module: `span_stage`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` and `pix_we` are 0. Every stored depth is set to all ones.
- R2: A packet accepted with start > PIX-1 causes no pixel write. In the next cycle, `out_valid` is 1 and the packet appears on `out_pkt` with start and stop each reduced by PIX and every other field unchanged.
- R3: A packet accepted with start <= PIX-1 produces one pixel cycle per local index, from max(0, start) to min(PIX-1, stop), in ascending order. The first pixel cycle is the cycle after acceptance. `pix_idx` gives the local index.
- R4: The first pixel shows the packet's channel values. For each later pixel, every channel takes value + whole step, and error + fractional step. If that error is at least the divisor, the value gains 1 more and the divisor is subtracted from the error. Arithmetic wraps at the channel width.
- R5: When stop <= PIX-1, no packet is forwarded and `in_ready` returns to 1 in the cycle after the last pixel.
- R6: When stop > PIX-1, the packet is forwarded in the cycle after pixel PIX-1. Its start and stop are each reduced by PIX, and its channel values and errors are those of the pixel after PIX-1. The divisor, the steps and the depth-test bit are unchanged. The stage is idle one cycle after a cycle with `out_valid` and `out_ready` both high.
- R7: The packet field `zcmp` (type `pkt_t` in `span_pkg`) enables the depth test. When it is 1, a pixel write is committed (`pix_we`=1) only if its depth is strictly less than the depth stored for that index. When it is 0, every pixel write is committed. A committed write stores its depth.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_pkt` stays unchanged and `out_valid` stays 1.
- R9: `in_ready` is 0 while the stage is writing pixels or holding a packet for forwarding. A packet offered during that time is not taken and causes no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming packet valid |
| in_ready | output | 1 | Stage idle and able to take a packet |
| in_pkt | input | PKT_W | Incoming span packet (`pkt_t`) |
| out_valid | output | 1 | Renormalized packet for the next stage is valid |
| out_ready | input | 1 | Next stage can take the packet |
| out_pkt | output | PKT_W | Renormalized span packet (`pkt_t`) |
| pix_we | output | 1 | Committed pixel write |
| pix_idx | output | IDX_W | Local pixel index of the write |
| pix_r | output | C_W | Red value of the pixel |
| pix_g | output | C_W | Green value of the pixel |
| pix_b | output | C_W | Blue value of the pixel |
| pix_z | output | Z_W | Depth value of the pixel |

## Verification
The bench targets the following corner cases:
- **Window boundaries.** Spans start exactly at 0, at PIX-1 and at PIX, and one span has a negative start. A wrong bound on the start test would either paint a pixel that belongs to the next stage or lose the first pixel of a span.
- **Error carry.** Fractional steps are chosen so that the error reaches the divisor exactly. A stepper that tests with "greater than" would drift by one.
- **Negative steps.** Channels with negative whole steps expose a stepper that fails to wrap.
- **Forwarded packet.** The forwarded packet is compared field by field. A stage that forwards the values of pixel PIX-1 instead of the next pixel would seam the span.
- **Depth ties and reset.** The depth test is run against stored depths equal to the incoming one, and again after a reset. A design using `<=` or keeping stale depths would commit writes it must reject.
- **Stalls.** Stalls with a competing input packet show whether the held packet is overwritten.

// File: rtl/span_pkg.sv
package span_pkg;

    localparam int POS_W = 8;   // signed span position width
    localparam int DIV_W = 8;   // divisor / fractional step / error width
    localparam int C_W   = 8;   // colour channel width
    localparam int Z_W   = 16;  // depth channel width
    localparam int N_COL = 3;   // colour channels per pixel

    typedef struct packed {
        logic [C_W-1:0]   val;
        logic [C_W-1:0]   whole;
        logic [DIV_W-1:0] frac;
        logic [DIV_W-1:0] err;
    } col_chan_t;

    typedef struct packed {
        logic [Z_W-1:0]   val;
        logic [Z_W-1:0]   whole;
        logic [DIV_W-1:0] frac;
        logic [DIV_W-1:0] err;
    } z_chan_t;

    typedef struct packed {
        logic                    zcmp;
        logic signed [POS_W-1:0] start;
        logic signed [POS_W-1:0] stop;
        logic [DIV_W-1:0]        divisor;
        col_chan_t [N_COL-1:0]   col;   // [0]=red [1]=green [2]=blue
        z_chan_t                 z;
    } pkt_t;

    localparam int PKT_W = $bits(pkt_t);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FWD  = 2'd2
    } stage_st_e;

endpackage

// File: rtl/span_chan_step.sv
module span_chan_step #(
    parameter int VAL_W = 8,
    parameter int ERR_W = 8
) (
    input  logic [VAL_W-1:0] val,
    input  logic [VAL_W-1:0] whole,
    input  logic [ERR_W-1:0] frac,
    input  logic [ERR_W-1:0] err,
    input  logic [ERR_W-1:0] divisor,
    output logic [VAL_W-1:0] val_nx,
    output logic [ERR_W-1:0] err_nx
);

    logic [ERR_W:0] acc;
    logic           carry;

    always_comb begin
        acc    = {1'b0, err} + {1'b0, frac};
        carry  = (acc >= {1'b0, divisor});
        err_nx = carry ? ERR_W'(acc - {1'b0, divisor}) : acc[ERR_W-1:0];
        val_nx = val + whole + VAL_W'(carry);
    end

endmodule

// File: rtl/span_zbuf.sv
module span_zbuf #(
    parameter int DEPTH = 16,
    parameter int W     = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_idx,
    output logic [W-1:0]  rd_z,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [W-1:0]  wr_z
);

    logic [W-1:0] mem_d [DEPTH];
    logic [W-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_idx] = wr_z;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '1;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_z = mem_q[rd_idx];

endmodule

// File: rtl/span_stage.sv
module span_stage
    import span_pkg::*;
#(
    parameter int PIX    = 16,
    localparam int IDX_W = $clog2(PIX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PKT_W-1:0] in_pkt,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PKT_W-1:0] out_pkt,
    output logic             pix_we,
    output logic [IDX_W-1:0] pix_idx,
    output logic [C_W-1:0]   pix_r,
    output logic [C_W-1:0]   pix_g,
    output logic [C_W-1:0]   pix_b,
    output logic [Z_W-1:0]   pix_z
);

    localparam logic signed [POS_W-1:0] LAST_S   = POS_W'(PIX - 1);
    localparam logic signed [POS_W-1:0] SHIFT_S  = POS_W'(PIX);
    localparam logic [IDX_W-1:0]        LAST_IDX = IDX_W'(PIX - 1);

    typedef struct packed {
        stage_st_e        st;
        logic [IDX_W-1:0] cur;
        pkt_t             pkt;
    } regs_t;

    regs_t r_d, r_q;
    pkt_t  in_p;
    pkt_t  stepped;
    logic  [Z_W-1:0] stored_z;
    logic  end_here;

    assign in_p = pkt_t'(in_pkt);

    function automatic pkt_t shift_window(input pkt_t p);
        pkt_t o;
        o       = p;
        o.start = p.start - SHIFT_S;
        o.stop  = p.stop - SHIFT_S;
        return o;
    endfunction

    // one stepper per colour channel
    for (genvar c = 0; c < N_COL; c++) begin : g_col
        span_chan_step #(.VAL_W(C_W), .ERR_W(DIV_W)) u_step (
            .val     (r_q.pkt.col[c].val),
            .whole   (r_q.pkt.col[c].whole),
            .frac    (r_q.pkt.col[c].frac),
            .err     (r_q.pkt.col[c].err),
            .divisor (r_q.pkt.divisor),
            .val_nx  (stepped.col[c].val),
            .err_nx  (stepped.col[c].err)
        );
        assign stepped.col[c].whole = r_q.pkt.col[c].whole;
        assign stepped.col[c].frac  = r_q.pkt.col[c].frac;
    end

    span_chan_step #(.VAL_W(Z_W), .ERR_W(DIV_W)) u_zstep (
        .val     (r_q.pkt.z.val),
        .whole   (r_q.pkt.z.whole),
        .frac    (r_q.pkt.z.frac),
        .err     (r_q.pkt.z.err),
        .divisor (r_q.pkt.divisor),
        .val_nx  (stepped.z.val),
        .err_nx  (stepped.z.err)
    );
    assign stepped.z.whole = r_q.pkt.z.whole;
    assign stepped.z.frac  = r_q.pkt.z.frac;
    assign stepped.zcmp    = r_q.pkt.zcmp;
    assign stepped.start   = r_q.pkt.start;
    assign stepped.stop    = r_q.pkt.stop;
    assign stepped.divisor = r_q.pkt.divisor;

    span_zbuf #(.DEPTH(PIX), .W(Z_W)) u_zbuf (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (r_q.cur),
        .rd_z   (stored_z),
        .wr_en  (pix_we),
        .wr_idx (r_q.cur),
        .wr_z   (r_q.pkt.z.val)
    );

    assign end_here = (r_q.pkt.stop <= LAST_S) && (POS_W'(r_q.cur) == r_q.pkt.stop);

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    if (in_p.start > LAST_S) begin
                        r_d.pkt = shift_window(in_p);
                        r_d.st  = ST_FWD;
                    end else begin
                        r_d.pkt = in_p;
                        r_d.cur = in_p.start[POS_W-1] ? '0 : in_p.start[IDX_W-1:0];
                        r_d.st  = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                r_d.pkt = stepped;
                if (end_here) begin
                    r_d.st = ST_IDLE;
                end else if (r_q.cur == LAST_IDX) begin
                    r_d.pkt = shift_window(stepped);
                    r_d.st  = ST_FWD;
                end else begin
                    r_d.cur = r_q.cur + 1'b1;
                end
            end
            ST_FWD: begin
                if (out_ready) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cur: '0, pkt: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign in_ready  = (r_q.st == ST_IDLE);
    assign out_valid = (r_q.st == ST_FWD);
    assign out_pkt   = r_q.pkt;
    assign pix_we    = (r_q.st == ST_RUN) &&
                       (!r_q.pkt.zcmp || (r_q.pkt.z.val < stored_z));
    assign pix_idx   = r_q.cur;
    assign pix_r     = r_q.pkt.col[0].val;
    assign pix_g     = r_q.pkt.col[1].val;
    assign pix_b     = r_q.pkt.col[2].val;
    assign pix_z     = r_q.pkt.z.val;

endmodule

// File: rtl/span_stage_chk.sv
module span_stage_chk
    import span_pkg::*;
#(
    parameter int PIX    = 16,
    localparam int IDX_W = $clog2(PIX)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [PKT_W-1:0] in_pkt,
    input logic             out_valid,
    input logic             out_ready,
    input logic [PKT_W-1:0] out_pkt,
    input logic             pix_we,
    input logic [IDX_W-1:0] pix_idx
);

    localparam logic signed [POS_W-1:0] LAST_S = POS_W'(PIX - 1);

    pkt_t in_p;
    assign in_p = pkt_t'(in_pkt);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (in_ready && !out_valid && !pix_we));

    // R2
    skip_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (in_p.start > LAST_S)) |=> (out_valid && !pix_we));

    // R3
    first_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (in_p.start <= LAST_S)) |=> (!out_valid && !in_ready));

    // R6
    handoff_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (in_ready && !out_valid));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pkt)));

    // R9
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid || pix_we) |-> !in_ready);

endmodule

bind span_stage span_stage_chk #(.PIX(PIX)) u_span_stage_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_pkt    (in_pkt),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pkt   (out_pkt),
    .pix_we    (pix_we),
    .pix_idx   (pix_idx)
);

// File: tb/span_stage_test.sv
module span_stage_test;
    import span_pkg::*;

    localparam int PIX = 16;

    typedef struct packed {
        logic signed [7:0] start;
        logic signed [7:0] stop;
        logic              zc;
        logic [7:0]        dv;
        logic [7:0]        rv, rq, rr, re;
        logic [15:0]       zv, zq;
        logic [7:0]        zr, ze;
    } vec_t;

    // start, stop, zcmp, div, red val/whole/frac/err, z val/whole/frac/err
    localparam vec_t VECS [7] = '{
        '{8'sd3,   8'sd9,  1'b0, 8'd7,  8'd10,  8'd5, 8'd3,  8'd5,  16'h1000, 16'h0010, 8'd2,  8'd6},
        '{8'sd10,  8'sd40, 1'b0, 8'd30, 8'd200, 8'd3, 8'd11, 8'd29, 16'h2000, 16'hFFF0, 8'd17, 8'd0},
        '{8'sd20,  8'sd30, 1'b0, 8'd5,  8'd1,   8'd2, 8'd4,  8'd0,  16'h3000, 16'h0001, 8'd3,  8'd4},
        '{-8'sd6,  8'sd24, 1'b0, 8'd9,  8'd50,  8'd1, 8'd8,  8'd8,  16'h4000, 16'h0100, 8'd0,  8'd0},
        '{8'sd0,   8'sd15, 1'b1, 8'd9,  8'd7,   8'd0, 8'd0,  8'd0,  16'h4800, 16'h0000, 8'd0,  8'd0},
        '{8'sd15,  8'sd15, 1'b0, 8'd4,  8'd99,  8'd9, 8'd1,  8'd3,  16'h0500, 16'h0002, 8'd1,  8'd2},
        '{8'sd16,  8'sd16, 1'b0, 8'd4,  8'd33,  8'd1, 8'd1,  8'd1,  16'h0600, 16'h0002, 8'd1,  8'd2}
    };

    // after reset: depth tie must be rejected, one less must commit
    localparam vec_t DIRS [2] = '{
        '{8'sd2, 8'sd2, 1'b1, 8'd4, 8'd1, 8'd0, 8'd0, 8'd0, 16'hFFFF, 16'h0, 8'd0, 8'd0},
        '{8'sd2, 8'sd2, 1'b1, 8'd4, 8'd2, 8'd0, 8'd0, 8'd0, 16'hFFFE, 16'h0, 8'd0, 8'd0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [PKT_W-1:0] in_pkt = '0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [PKT_W-1:0] out_pkt;
    logic             pix_we;
    logic [3:0]       pix_idx;
    logic [7:0]       pix_r, pix_g, pix_b;
    logic [15:0]      pix_z;

    int errors = 0;
    int checks = 0;
    logic [15:0] zmodel [PIX];

    always #5 clk = ~clk;

    span_stage #(.PIX(PIX)) uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_pkt(in_pkt),
        .out_valid(out_valid), .out_ready(out_ready), .out_pkt(out_pkt),
        .pix_we(pix_we), .pix_idx(pix_idx),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b), .pix_z(pix_z)
    );

    task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void step8(inout logic [7:0] v, inout logic [7:0] e,
                                  input logic [7:0] q, input logic [7:0] r, input logic [7:0] d);
        logic [8:0] s;
        s = {1'b0, e} + {1'b0, r};
        v = v + q;
        if (s >= {1'b0, d}) begin
            s = s - {1'b0, d};
            v = v + 8'd1;
        end
        e = s[7:0];
    endfunction

    function automatic void step16(inout logic [15:0] v, inout logic [7:0] e,
                                   input logic [15:0] q, input logic [7:0] r, input logic [7:0] d);
        logic [8:0] s;
        s = {1'b0, e} + {1'b0, r};
        v = v + q;
        if (s >= {1'b0, d}) begin
            s = s - {1'b0, d};
            v = v + 16'd1;
        end
        e = s[7:0];
    endfunction

    function automatic pkt_t mk_pkt(input vec_t v);
        pkt_t p;
        p.zcmp    = v.zc;
        p.start   = v.start;
        p.stop    = v.stop;
        p.divisor = v.dv;
        p.col[0]  = '{val: v.rv,          whole: v.rq,          frac: v.rr, err: v.re};
        p.col[1]  = '{val: v.rv ^ 8'h55,  whole: 8'd0 - v.rq,   frac: v.rr, err: v.re};
        p.col[2]  = '{val: v.rv + 8'd100, whole: v.rq + 8'd1,   frac: v.rr, err: 8'd0};
        p.z       = '{val: v.zv, whole: v.zq, frac: v.zr, err: v.ze};
        return p;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        out_ready = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < PIX; i++) zmodel[i] = 16'hFFFF;
        @(negedge clk);
        // R1
        chk(in_ready && !out_valid && !pix_we, "R1 reset state",
            {in_ready, out_valid, pix_we}, 3'b100);
    endtask

    task automatic run_vec(input vec_t v);
        pkt_t m;
        pkt_t junk;
        int   first, last;
        logic commit;
        m = mk_pkt(v);
        @(negedge clk);
        in_pkt   = m;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        if (v.start > 8'sd15) begin
            m.start = m.start - 8'sd16;
            m.stop  = m.stop - 8'sd16;
            // R2
            chk(out_valid && !pix_we, "R2 skip forwards at once", {out_valid, pix_we}, 2'b10);
            chk(out_pkt == m, "R2 skip packet shifted", out_pkt, m);
        end else begin
            first = (v.start < 0) ? 0 : int'(v.start);
            last  = (v.stop > 8'sd15) ? 15 : int'(v.stop);
            for (int x = first; x <= last; x++) begin
                commit = !m.zcmp || (m.z.val < zmodel[x]);
                // R3 R4 R7
                chk({pix_we, pix_idx, pix_r, pix_g, pix_b, pix_z} ==
                    {commit, 4'(x), m.col[0].val, m.col[1].val, m.col[2].val, m.z.val},
                    "R3/R4/R7 pixel write",
                    {pix_we, pix_idx, pix_r, pix_g, pix_b, pix_z},
                    {commit, 4'(x), m.col[0].val, m.col[1].val, m.col[2].val, m.z.val});
                if (commit) zmodel[x] = m.z.val;
                for (int c = 0; c < N_COL; c++)
                    step8(m.col[c].val, m.col[c].err, m.col[c].whole, m.col[c].frac, m.divisor);
                step16(m.z.val, m.z.err, m.z.whole, m.z.frac, m.divisor);
                @(negedge clk);
            end
            if (v.stop > 8'sd15) begin
                m.start = m.start - 8'sd16;
                m.stop  = m.stop - 8'sd16;
                // R6
                chk(out_valid && !pix_we, "R6 forward after last pixel", {out_valid, pix_we}, 2'b10);
                chk(out_pkt == m, "R6 forwarded packet continues span", out_pkt, m);
            end else begin
                // R5
                chk(!out_valid && in_ready && !pix_we, "R5 span ends here, no forward",
                    {out_valid, in_ready, pix_we}, 3'b010);
            end
        end
        if (out_valid) begin
            junk = mk_pkt(VECS[0]);
            in_pkt   = junk;
            in_valid = 1'b1;
            for (int k = 0; k < 2; k++) begin
                @(negedge clk);
                // R8
                chk(out_valid && out_pkt == m, "R8 stall holds packet", out_pkt, m);
                // R9
                chk(!in_ready && !pix_we, "R9 busy refuses input", {in_ready, pix_we}, 2'b00);
            end
            in_valid  = 1'b0;
            out_ready = 1'b1;
            @(negedge clk);
            out_ready = 1'b0;
            // R6
            chk(!out_valid && in_ready, "R6 idle after handoff", {out_valid, in_ready}, 2'b01);
        end
    endtask

    bit done = 1'b0;

    initial begin
        do_reset();
        foreach (VECS[i]) run_vec(VECS[i]);
        // directed: depth store cleared by reset, tie rejected, smaller accepted
        do_reset();
        run_vec(DIRS[0]);
        run_vec(DIRS[1]);
        // a second tie against the freshly stored depth must be rejected (R7)
        run_vec(DIRS[1]);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule